// File: doc/BRIEF.md
# Single-Precision Sign, Compare and Classify Unit

This unit carries out the non-arithmetic single-precision float operations of a scalar core. The operations are sign injection, ordered compares, minimum and maximum, classification, and raw moves of bit patterns between the integer and float register files. It works only on the bit patterns of IEEE-754 binary32 values. It never rounds or converts. NaNs, signed zeros and subnormals are each handled as their own case.

Each operation arrives in one cycle. It brings two float operands, one integer operand, and the three selector fields from the instruction word: the seven-bit group, the three-bit variant and the five-bit auxiliary field. One cycle later the unit presents a registered result. Two flags say whether the result goes to the integer file or to the float file. A selector combination that is not recognised raises an illegal flag and targets neither file.

Top module: `fp_sign_cmp_class`

## Requirements
- R1: With group 0010000 and variant 000, the result is bits [30:0] of operand A joined with the sign bit of operand B, and it goes to the float destination.
- R2: With group 0010000, variant 001 gives A's magnitude with the inverted sign of B, and variant 010 gives A's magnitude with the XOR of both signs, both to the float destination.
- R3: With group 1010000, variant 010 tests equal, 001 tests less-than and 000 tests less-or-equal. The result is 1 or 0 in bit 0 with all higher bits zero, sent to the integer destination. +0 and -0 compare equal.
- R4: Every compare in which either operand is a NaN (quiet or signalling) returns 0.
- R5: With group 0010100, variant 000 returns the smaller and 001 the larger operand to the float destination. For these two operations -0 is ordered below +0.
- R6: For min/max, if exactly one operand is a NaN the other operand is returned unchanged. If both are NaN, the result is 0x7FC00000.
- R7: With group 1110000, variant 001 and auxiliary field 0, the integer result is a one-hot mask of operand A. The bits are: bit0 -inf, bit1 negative normal, bit2 negative subnormal, bit3 -0, bit4 +0, bit5 positive subnormal, bit6 positive normal, bit7 +inf, bit8 signalling NaN, bit9 quiet NaN.
- R8: A NaN (exponent all ones, mantissa nonzero) is quiet when mantissa bit 22 is set and signalling when it is clear, whatever its sign. Exponent zero with a nonzero mantissa is subnormal.
- R9: Group 1110000 with variant 000 and auxiliary field 0 copies operand A unchanged to the integer destination. Group 1111000 with variant 000 and auxiliary field 0 copies the integer operand unchanged to the float destination.
- R10: A result appears exactly one cycle after a cycle with the input valid high, with exactly one destination flag set. In every other cycle the valid flag, both destination flags and the data are low.
- R11: Any other selector combination gives the illegal flag together with valid, both destination flags low, and data zero.
- R12: While reset is high, and in the cycle after, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src_a | input | 32 | First float operand bit pattern |
| src_b | input | 32 | Second float operand bit pattern |
| src_int | input | 32 | Integer operand for the int-to-float move |
| op_grp | input | 7 | Operation group selector |
| op_var | input | 3 | Variant selector within the group |
| op_aux | input | 5 | Auxiliary selector, must be zero for classify and moves |
| res_valid | output | 1 | Result present |
| res_data | output | 32 | Result bits |
| res_to_int | output | 1 | Result targets the integer register file |
| res_to_flt | output | 1 | Result targets the float register file |
| res_illegal | output | 1 | Selector combination not recognised |

## Verification
Compares are run on pairs that differ only in sign, on pairs of negatives (which reverse the magnitude order), on mixed signed zeros, and on quiet and signalling NaNs. These show whether a design orders the values by sign and magnitude or by raw integer value. Min and max are given zeros of opposite sign, a single NaN on either side, and two NaNs, which separate the ordering of zeros from the NaN fallbacks. Classification runs through one pattern per mask bit, plus a negative quiet NaN and the smallest subnormals, which locate the quiet bit and the subnormal boundary. Illegal selectors and idle cycles check that nothing reaches either register file.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

  localparam logic [6:0] GRP_SIGN   = 7'b0010000;
  localparam logic [6:0] GRP_CMP    = 7'b1010000;
  localparam logic [6:0] GRP_MINMAX = 7'b0010100;
  localparam logic [6:0] GRP_F2X    = 7'b1110000;
  localparam logic [6:0] GRP_X2F    = 7'b1111000;

  localparam int CLASS_W = 10;

  typedef enum logic [3:0] {
    OP_SGN_COPY,
    OP_SGN_NEG,
    OP_SGN_XOR,
    OP_CMP_EQ,
    OP_CMP_LT,
    OP_CMP_LE,
    OP_MIN,
    OP_MAX,
    OP_CLASS,
    OP_MOVE_F2X,
    OP_MOVE_X2F,
    OP_NONE
  } fbu_op_e;

  typedef struct packed {
    logic sign;
    logic is_inf;
    logic is_zero;
    logic is_sub;
    logic is_norm;
    logic is_snan;
    logic is_qnan;
  } fbu_attr_t;

endpackage

// File: rtl/fbu_decode.sv
module fbu_decode
  import fbu_pkg::*;
(
  input  logic [6:0] grp,
  input  logic [2:0] var_sel,
  input  logic [4:0] aux,
  output fbu_op_e    op,
  output logic       to_int,
  output logic       to_flt,
  output logic       illegal
);

  always_comb begin
    op = OP_NONE;
    unique case (grp)
      GRP_SIGN: begin
        case (var_sel)
          3'b000:  op = OP_SGN_COPY;
          3'b001:  op = OP_SGN_NEG;
          3'b010:  op = OP_SGN_XOR;
          default: op = OP_NONE;
        endcase
      end
      GRP_CMP: begin
        case (var_sel)
          3'b010:  op = OP_CMP_EQ;
          3'b001:  op = OP_CMP_LT;
          3'b000:  op = OP_CMP_LE;
          default: op = OP_NONE;
        endcase
      end
      GRP_MINMAX: begin
        case (var_sel)
          3'b000:  op = OP_MIN;
          3'b001:  op = OP_MAX;
          default: op = OP_NONE;
        endcase
      end
      GRP_F2X: begin
        if (aux == 5'd0) begin
          case (var_sel)
            3'b000:  op = OP_MOVE_F2X;
            3'b001:  op = OP_CLASS;
            default: op = OP_NONE;
          endcase
        end
      end
      GRP_X2F: begin
        if (aux == 5'd0 && var_sel == 3'b000) op = OP_MOVE_X2F;
      end
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    to_int  = 1'b0;
    to_flt  = 1'b0;
    illegal = 1'b0;
    case (op)
      OP_SGN_COPY, OP_SGN_NEG, OP_SGN_XOR,
      OP_MIN, OP_MAX, OP_MOVE_X2F:           to_flt  = 1'b1;
      OP_CMP_EQ, OP_CMP_LT, OP_CMP_LE,
      OP_CLASS, OP_MOVE_F2X:                 to_int  = 1'b1;
      default:                               illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/fbu_unpack.sv
module fbu_unpack
  import fbu_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] bits,
  output fbu_attr_t            attr,
  output logic                 is_nan
);

  localparam int FW = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic             ex_ones;
  logic             ex_zero;
  logic             mn_zero;

  assign ex      = bits[FW-2 -: EXP_W];
  assign mn      = bits[MAN_W-1:0];
  assign ex_ones = &ex;
  assign ex_zero = ~|ex;
  assign mn_zero = ~|mn;

  always_comb begin
    attr.sign    = bits[FW-1];
    attr.is_inf  = ex_ones & mn_zero;
    attr.is_zero = ex_zero & mn_zero;
    attr.is_sub  = ex_zero & ~mn_zero;
    attr.is_norm = ~ex_zero & ~ex_ones;
    attr.is_qnan = ex_ones & mn[MAN_W-1];
    attr.is_snan = ex_ones & ~mn[MAN_W-1] & ~mn_zero;
  end

  assign is_nan = ex_ones & ~mn_zero;

endmodule

// File: rtl/fbu_classify.sv
module fbu_classify
  import fbu_pkg::*;
(
  input  fbu_attr_t          attr,
  output logic [CLASS_W-1:0] mask
);

  always_comb begin
    mask    = '0;
    mask[0] =  attr.sign & attr.is_inf;
    mask[1] =  attr.sign & attr.is_norm;
    mask[2] =  attr.sign & attr.is_sub;
    mask[3] =  attr.sign & attr.is_zero;
    mask[4] = ~attr.sign & attr.is_zero;
    mask[5] = ~attr.sign & attr.is_sub;
    mask[6] = ~attr.sign & attr.is_norm;
    mask[7] = ~attr.sign & attr.is_inf;
    mask[8] =  attr.is_snan;
    mask[9] =  attr.is_qnan;
  end

  always_comb begin
    assert_class_onehot_R7: assert ($onehot(mask));
  end

endmodule

// File: rtl/fbu_compare.sv
module fbu_compare #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  logic                 a_nan,
  input  logic                 b_nan,
  input  logic                 a_zero,
  input  logic                 b_zero,
  output logic                 eq,
  output logic                 lt,
  output logic                 le,
  output logic [EXP_W+MAN_W:0] min_val,
  output logic [EXP_W+MAN_W:0] max_val
);

  localparam int FW = 1 + EXP_W + MAN_W;
  localparam logic [FW-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic            sa, sb;
  logic [FW-2:0]   ma, mb;
  logic            any_nan;
  logic            both_zero;
  logic            mag_lt, mag_gt;
  logic            ord_lt;

  assign sa        = a[FW-1];
  assign sb        = b[FW-1];
  assign ma        = a[FW-2:0];
  assign mb        = b[FW-2:0];
  assign any_nan   = a_nan | b_nan;
  assign both_zero = a_zero & b_zero;
  assign mag_lt    = ma < mb;
  assign mag_gt    = ma > mb;

  // ordering with -0 placed below +0
  always_comb begin
    if (sa != sb) ord_lt = sa;
    else if (sa)  ord_lt = mag_gt;
    else          ord_lt = mag_lt;
  end

  always_comb begin
    eq = ~any_nan & ((a == b) | both_zero);
    lt = ~any_nan & ~both_zero & ord_lt;
    le = ~any_nan & (both_zero | ord_lt | (a == b));
  end

  always_comb begin
    if (a_nan & b_nan) begin
      min_val = CANON_NAN;
      max_val = CANON_NAN;
    end else if (a_nan) begin
      min_val = b;
      max_val = b;
    end else if (b_nan) begin
      min_val = a;
      max_val = a;
    end else begin
      min_val = ord_lt ? a : b;
      max_val = ord_lt ? b : a;
    end
  end

endmodule

// File: rtl/fp_sign_cmp_class.sv
module fp_sign_cmp_class
  import fbu_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] src_a,
  input  logic [EXP_W+MAN_W:0] src_b,
  input  logic [EXP_W+MAN_W:0] src_int,
  input  logic [6:0]           op_grp,
  input  logic [2:0]           op_var,
  input  logic [4:0]           op_aux,
  output logic                 res_valid,
  output logic [EXP_W+MAN_W:0] res_data,
  output logic                 res_to_int,
  output logic                 res_to_flt,
  output logic                 res_illegal
);

  localparam int FW = 1 + EXP_W + MAN_W;
  localparam int NOPS = 2;

  fbu_op_e          op;
  logic             dec_int, dec_flt, dec_ill;
  fbu_attr_t        attr [NOPS];
  logic [NOPS-1:0]  nan_v;
  logic [FW-1:0]    opnd [NOPS];
  logic [CLASS_W-1:0] cls_mask;
  logic             c_eq, c_lt, c_le;
  logic [FW-1:0]    v_min, v_max;
  logic [FW-1:0]    result;

  assign opnd[0] = src_a;
  assign opnd[1] = src_b;

  fbu_decode u_decode (
    .grp     (op_grp),
    .var_sel (op_var),
    .aux     (op_aux),
    .op      (op),
    .to_int  (dec_int),
    .to_flt  (dec_flt),
    .illegal (dec_ill)
  );

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_unpack
    fbu_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .bits   (opnd[gi]),
      .attr   (attr[gi]),
      .is_nan (nan_v[gi])
    );
  end

  fbu_classify u_classify (
    .attr (attr[0]),
    .mask (cls_mask)
  );

  fbu_compare #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_compare (
    .a       (src_a),
    .b       (src_b),
    .a_nan   (nan_v[0]),
    .b_nan   (nan_v[1]),
    .a_zero  (attr[0].is_zero),
    .b_zero  (attr[1].is_zero),
    .eq      (c_eq),
    .lt      (c_lt),
    .le      (c_le),
    .min_val (v_min),
    .max_val (v_max)
  );

  always_comb begin
    case (op)
      OP_SGN_COPY: result = {src_b[FW-1],          src_a[FW-2:0]};
      OP_SGN_NEG:  result = {~src_b[FW-1],         src_a[FW-2:0]};
      OP_SGN_XOR:  result = {src_a[FW-1] ^ src_b[FW-1], src_a[FW-2:0]};
      OP_CMP_EQ:   result = {{(FW-1){1'b0}}, c_eq};
      OP_CMP_LT:   result = {{(FW-1){1'b0}}, c_lt};
      OP_CMP_LE:   result = {{(FW-1){1'b0}}, c_le};
      OP_MIN:      result = v_min;
      OP_MAX:      result = v_max;
      OP_CLASS:    result = {{(FW-CLASS_W){1'b0}}, cls_mask};
      OP_MOVE_F2X: result = src_a;
      OP_MOVE_X2F: result = src_int;
      default:     result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_to_int  <= 1'b0;
      res_to_flt  <= 1'b0;
      res_illegal <= 1'b0;
    end else if (in_valid) begin
      res_valid   <= 1'b1;
      res_data    <= dec_ill ? '0 : result;
      res_to_int  <= dec_int;
      res_to_flt  <= dec_flt;
      res_illegal <= dec_ill;
    end else begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_to_int  <= 1'b0;
      res_to_flt  <= 1'b0;
      res_illegal <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  logic sel_sign, sel_cmp, sel_mm, sel_x2f;
  assign sel_sign = (op_grp == GRP_SIGN)   && (op_var == 3'b000 || op_var == 3'b001 || op_var == 3'b010);
  assign sel_cmp  = (op_grp == GRP_CMP)    && (op_var == 3'b000 || op_var == 3'b001 || op_var == 3'b010);
  assign sel_mm   = (op_grp == GRP_MINMAX) && (op_var == 3'b000 || op_var == 3'b001);
  assign sel_x2f  = (op_grp == GRP_X2F)    && (op_var == 3'b000) && (op_aux == 5'd0);

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !res_to_int && !res_to_flt && res_data == '0));

  assert_one_dest_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_illegal) |-> $onehot({res_to_int, res_to_flt}));

  assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    res_illegal |-> (res_valid && !res_to_int && !res_to_flt && res_data == '0));

  assert_sign_mag_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_sign) |=> (res_to_flt && res_data[FW-2:0] == $past(src_a[FW-2:0])));

  assert_cmp_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_cmp) |=> (res_to_int && res_data[FW-1:1] == '0));

  assert_cmp_nan_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_cmp && (nan_v[0] || nan_v[1])) |=> (res_data == '0));

  assert_minmax_pick_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_mm && !nan_v[0] && !nan_v[1]) |=>
      (res_data == $past(src_a) || res_data == $past(src_b)));

  assert_move_x2f_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_x2f) |=> (res_to_flt && res_data == $past(src_int)));

endmodule

// File: tb/fp_sign_cmp_class_bench.sv
module fp_sign_cmp_class_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, src_int = '0;
  logic [6:0]  op_grp = '0;
  logic [2:0]  op_var = '0;
  logic [4:0]  op_aux = '0;
  logic        res_valid, res_to_int, res_to_flt, res_illegal;
  logic [31:0] res_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [6:0] G_SGN = 7'b0010000;
  localparam logic [6:0] G_CMP = 7'b1010000;
  localparam logic [6:0] G_MM  = 7'b0010100;
  localparam logic [6:0] G_F2X = 7'b1110000;
  localparam logic [6:0] G_X2F = 7'b1111000;

  localparam logic [31:0] P_ONE  = 32'h3F800000;
  localparam logic [31:0] N_ONE  = 32'hBF800000;
  localparam logic [31:0] P_TWO  = 32'h40000000;
  localparam logic [31:0] N_TWO  = 32'hC0000000;
  localparam logic [31:0] P_ZERO = 32'h00000000;
  localparam logic [31:0] N_ZERO = 32'h80000000;
  localparam logic [31:0] QNAN   = 32'h7FC00000;
  localparam logic [31:0] SNAN   = 32'h7F800001;

  always #4 clk = ~clk;

  fp_sign_cmp_class u_fp_sign_cmp_class (
    .clk (clk), .rst (rst), .in_valid (in_valid),
    .src_a (src_a), .src_b (src_b), .src_int (src_int),
    .op_grp (op_grp), .op_var (op_var), .op_aux (op_aux),
    .res_valid (res_valid), .res_data (res_data),
    .res_to_int (res_to_int), .res_to_flt (res_to_flt),
    .res_illegal (res_illegal)
  );

  task automatic check(input string tag, input logic [31:0] exp_d,
                       input bit exp_v, input bit exp_i, input bit exp_f, input bit exp_x);
    n_run++;
    if (res_data !== exp_d || res_valid !== exp_v || res_to_int !== exp_i ||
        res_to_flt !== exp_f || res_illegal !== exp_x) begin
      n_fail++;
      $display("FAIL %s data=%h exp=%h valid=%0b/%0b int=%0b/%0b flt=%0b/%0b ill=%0b/%0b",
               tag, res_data, exp_d, res_valid, exp_v, res_to_int, exp_i,
               res_to_flt, exp_f, res_illegal, exp_x);
    end
  endtask

  // drive at a falling edge, sample at the following falling edge
  task automatic issue(input logic [6:0] g, input logic [2:0] v, input logic [4:0] e,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] x);
    @(negedge clk);
    op_grp = g; op_var = v; op_aux = e;
    src_a = a; src_b = b; src_int = x;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic flt_op(input string tag, input logic [6:0] g, input logic [2:0] v,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp_d);
    issue(g, v, 5'd0, a, b, 32'h0);
    check(tag, exp_d, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic int_op(input string tag, input logic [6:0] g, input logic [2:0] v,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp_d);
    issue(g, v, 5'd0, a, b, 32'h0);
    check(tag, exp_d, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    check("R12 reset", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    check("R12 after reset", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sign;
    flt_op("R1 copy sign neg",  G_SGN, 3'b000, P_ONE, N_ZERO, N_ONE);
    flt_op("R1 copy sign pos",  G_SGN, 3'b000, N_TWO, P_ONE,  P_TWO);
    flt_op("R2 inverted sign",  G_SGN, 3'b001, N_ONE, N_ZERO, P_ONE);
    flt_op("R2 inverted sign2", G_SGN, 3'b001, P_ONE, P_ZERO, N_ONE);
    flt_op("R2 xor signs",      G_SGN, 3'b010, N_TWO, N_ZERO, P_TWO);
    flt_op("R2 xor signs2",     G_SGN, 3'b010, P_TWO, N_ONE,  N_TWO);
  endtask

  task automatic t_compare;
    int_op("R3 eq equal",        G_CMP, 3'b010, P_ONE,  P_ONE,  32'd1);
    int_op("R3 eq signed zeros", G_CMP, 3'b010, P_ZERO, N_ZERO, 32'd1);
    int_op("R3 eq differ",       G_CMP, 3'b010, P_ONE,  N_ONE,  32'd0);
    int_op("R3 lt sign",         G_CMP, 3'b001, N_ONE,  P_ONE,  32'd1);
    int_op("R3 lt negatives",    G_CMP, 3'b001, N_TWO,  N_ONE,  32'd1);
    int_op("R3 lt negatives rev",G_CMP, 3'b001, N_ONE,  N_TWO,  32'd0);
    int_op("R3 lt positives",    G_CMP, 3'b001, P_TWO,  P_ONE,  32'd0);
    int_op("R3 lt zeros",        G_CMP, 3'b001, N_ZERO, P_ZERO, 32'd0);
    int_op("R3 le zeros",        G_CMP, 3'b000, P_ZERO, N_ZERO, 32'd1);
    int_op("R3 le equal",        G_CMP, 3'b000, N_TWO,  N_TWO,  32'd1);
    int_op("R3 le greater",      G_CMP, 3'b000, P_TWO,  N_TWO,  32'd0);
    int_op("R4 eq both nan",     G_CMP, 3'b010, QNAN,   QNAN,   32'd0);
    int_op("R4 le qnan",         G_CMP, 3'b000, QNAN,   P_ONE,  32'd0);
    int_op("R4 lt snan",         G_CMP, 3'b001, N_ONE,  SNAN,   32'd0);
    int_op("R4 eq snan self",    G_CMP, 3'b010, SNAN,   SNAN,   32'd0);
  endtask

  task automatic t_minmax;
    flt_op("R5 min zeros",      G_MM, 3'b000, P_ZERO, N_ZERO, N_ZERO);
    flt_op("R5 max zeros",      G_MM, 3'b001, N_ZERO, P_ZERO, P_ZERO);
    flt_op("R5 min mixed",      G_MM, 3'b000, P_ONE,  N_TWO,  N_TWO);
    flt_op("R5 max negatives",  G_MM, 3'b001, N_TWO,  N_ONE,  N_ONE);
    flt_op("R5 min negatives",  G_MM, 3'b000, N_ONE,  N_TWO,  N_TWO);
    flt_op("R6 min b nan",      G_MM, 3'b000, P_ONE,  QNAN,   P_ONE);
    flt_op("R6 max a nan",      G_MM, 3'b001, SNAN,   P_TWO,  P_TWO);
    flt_op("R6 min both nan",   G_MM, 3'b000, SNAN,   32'hFFC00123, QNAN);
    flt_op("R6 max both nan",   G_MM, 3'b001, 32'hFF800005, QNAN, QNAN);
  endtask

  task automatic t_classify;
    int_op("R7 -inf",        G_F2X, 3'b001, 32'hFF800000, 0, 32'h001);
    int_op("R7 neg normal",  G_F2X, 3'b001, N_ONE,        0, 32'h002);
    int_op("R7 neg sub",     G_F2X, 3'b001, 32'h80000001, 0, 32'h004);
    int_op("R7 -0",          G_F2X, 3'b001, N_ZERO,       0, 32'h008);
    int_op("R7 +0",          G_F2X, 3'b001, P_ZERO,       0, 32'h010);
    int_op("R7 pos sub",     G_F2X, 3'b001, 32'h00000001, 0, 32'h020);
    int_op("R7 pos normal",  G_F2X, 3'b001, P_TWO,        0, 32'h040);
    int_op("R7 +inf",        G_F2X, 3'b001, 32'h7F800000, 0, 32'h080);
    int_op("R8 snan",        G_F2X, 3'b001, SNAN,         0, 32'h100);
    int_op("R8 qnan",        G_F2X, 3'b001, QNAN,         0, 32'h200);
    int_op("R8 neg qnan",    G_F2X, 3'b001, 32'hFFC00001, 0, 32'h200);
    int_op("R8 neg snan",    G_F2X, 3'b001, 32'hFFBFFFFF, 0, 32'h100);
    int_op("R8 largest sub", G_F2X, 3'b001, 32'h007FFFFF, 0, 32'h020);
    int_op("R8 smallest nrm",G_F2X, 3'b001, 32'h00800000, 0, 32'h040);
  endtask

  task automatic t_moves;
    int_op("R9 float to int", G_F2X, 3'b000, SNAN, P_ONE, SNAN);
    issue(G_X2F, 3'b000, 5'd0, P_ONE, P_TWO, 32'hDEADBEEF);
    check("R9 int to float", 32'hDEADBEEF, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_illegal;
    issue(G_SGN, 3'b011, 5'd0, P_ONE, N_ONE, 32'h1234);
    check("R11 bad sign variant", 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(G_F2X, 3'b001, 5'd1, P_ONE, N_ONE, 32'h1234);
    check("R11 classify aux", 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(G_X2F, 3'b000, 5'd2, P_ONE, N_ONE, 32'h1234);
    check("R11 move aux", 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(7'b0000000, 3'b000, 5'd0, P_ONE, N_ONE, 32'h1234);
    check("R11 unknown group", 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(G_MM, 3'b010, 5'd0, P_ONE, N_ONE, 32'h1234);
    check("R11 bad minmax variant", 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_latency;
    issue(G_SGN, 3'b000, 5'd0, P_TWO, N_ONE, 32'h0);
    check("R10 result cycle", N_TWO, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 idle cycle", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    // back-to-back issue
    @(negedge clk);
    op_grp = G_CMP; op_var = 3'b001; op_aux = 5'd0; src_a = N_ONE; src_b = P_ONE;
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 back to back first", 32'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    op_grp = G_MM; op_var = 3'b001; src_a = N_ONE; src_b = P_ONE;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 back to back second", P_ONE, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_sign();
    t_compare();
    t_minmax();
    t_classify();
    t_moves();
    t_illegal();
    t_latency();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule